// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the divider settings of a clock synthesizer: a 9-bit feedback divide value, a 3-bit output divide code and a 2-bit selector for a test pin. The settings come from one of two sources. The first is a set of wide parallel pins with an active-low load strobe. The second is a three-wire serial port made of a serial clock, serial data and a load strobe. A fast system clock samples every control pin through a two-stage synchronizer and finds the edges of each pin itself. No pin acts as a clock.

When the parallel strobe is low, the block is in parallel mode and the parallel pins drive the settings directly. When the strobe rises, the settings are frozen. When the strobe is high, the serial port takes over. Each serial clock edge shifts in one bit. A rising serial load strobe copies the frame into the settings, and the settings stay latched after the strobe falls. If the serial load strobe is held high, every serial clock edge updates the settings at once. The test pin can show a constant low, the serial data input, or the feedback divider output that the block receives. The block also flags feedback values outside the lock range.

Top module: `synth_div_loader`

## Requirements
- R1: After reset, `m_o`, `n_o` and `tsel_o` are zero, `test_o` is low, and the block is in parallel mode.
- R2: While `par_load_ni` is low, `m_o` and `n_o` follow `par_m_i` and `par_n_i` within 3 system clock cycles, `tsel_o` is 00 and `test_o` is low.
- R3: After `par_load_ni` rises, `m_o` and `n_o` keep the last values tracked. Later changes on `par_m_i` or `par_n_i` do not affect them.
- R4: While `par_load_ni` is high, each rising edge of `ser_clk_i` shifts `ser_data_i` into a 14-bit register. The outputs do not change while `ser_load_i` stays low.
- R5: A rising `ser_load_i` (with `par_load_ni` high) copies the register into the outputs. In a 14-bit frame, the first bit shifted lands in `tsel_o[1]`, then `tsel_o[0]`, then `n_o[2:0]` from MSB down, then `m_o[8:0]` from MSB down. The last bit lands in `m_o[0]`.
- R6: After `ser_load_i` falls, the outputs stay latched while further serial bits are shifted.
- R7: While `ser_load_i` is held high, each rising edge of `ser_clk_i` puts the newly shifted register contents on the outputs.
- R8: `test_o` depends on `tsel_o`: 00 gives low, 01 gives `ser_data_i`, 10 gives `fb_div_i`, and 11 gives low. In parallel mode, `test_o` is low.
- R9: `m_range_err_o` is high exactly when `m_o` is below 250 or above 500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_load_ni | input | 1 | Parallel load strobe, active low |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 3 | Parallel output divide code |
| ser_clk_i | input | 1 | Serial shift clock, sampled |
| ser_data_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Serial load strobe |
| fb_div_i | input | 1 | Feedback divider output, used by the test mux |
| m_o | output | 9 | Active feedback divide value |
| n_o | output | 3 | Active output divide code |
| tsel_o | output | 2 | Active test select |
| test_o | output | 1 | Test pin |
| m_range_err_o | output | 1 | Feedback value outside the lock range |

## Verification
The assertions assume that every pin level lasts at least three system clock cycles. Each serial clock edge, strobe edge and parallel data change must therefore reach the synchronizer output cleanly, and no two edges of one pin may fall inside one synchronizer window. The parallel data is assumed stable around the rising edge of its strobe. The bench holds every pin level for four or more cycles and changes the parallel data only while the strobe is steady. It never moves the serial clock and the serial load strobe in the same cycle, so the order of events is never ambiguous.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  parameter int M_W = 9;
  parameter int N_W = 3;
  parameter int T_W = 2;
  localparam int FRAME_W = M_W + N_W + T_W;

  // field order matches serial frame: first bit shifted -> tsel MSB
  typedef struct packed {
    logic [T_W-1:0] tsel;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [1:0] {
    TSEL_LOW  = 2'b00,
    TSEL_DATA = 2'b01,
    TSEL_FB   = 2'b10,
    TSEL_RSVD = 2'b11
  } tsel_e;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdl_shift.sv
module sdl_shift
  import sdl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] sr_o,
  output logic [FRAME_W-1:0] sr_next_o
);
  logic [FRAME_W-1:0] sr_q;

  assign sr_next_o = {sr_q[FRAME_W-2:0], bit_i};
  assign sr_o      = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= sr_next_o;
  end

  assert_shift_in_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (sr_q[0] == $past(bit_i)) &&
                   (sr_q[FRAME_W-1:1] == $past(sr_q[FRAME_W-2:0])));
endmodule

// File: rtl/sdl_cfg.sv
module sdl_cfg
  import sdl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               par_mode_i,
  input  logic [M_W-1:0]     par_m_i,
  input  logic [N_W-1:0]     par_n_i,
  input  logic               s_load_i,
  input  logic               s_load_rise_i,
  input  logic               s_clk_rise_i,
  input  logic [FRAME_W-1:0] sr_i,
  input  logic [FRAME_W-1:0] sr_next_i,
  output cfg_t               cfg_o
);
  cfg_t cfg_q;
  logic ser_upd;

  // serial update: strobe edge, or transparent shift while strobe high
  assign ser_upd = s_load_rise_i || (s_load_i && s_clk_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (par_mode_i) begin
      cfg_q.m    <= par_m_i;
      cfg_q.n    <= par_n_i;
      cfg_q.tsel <= '0;
    end else if (ser_upd) begin
      cfg_q <= s_clk_rise_i ? cfg_t'(sr_next_i) : cfg_t'(sr_i);
    end
  end

  assign cfg_o = cfg_q;

  assert_par_track_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode_i |=> (cfg_q.m == $past(par_m_i)) && (cfg_q.n == $past(par_n_i)) &&
                   (cfg_q.tsel == '0));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_mode_i && !s_load_rise_i && !s_load_i) |=> $stable(cfg_q));

  assert_serial_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_mode_i && s_load_rise_i && !s_clk_rise_i) |=> (cfg_q == $past(sr_i)));

  assert_transparent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_mode_i && s_load_i && s_clk_rise_i) |=> (cfg_q == $past(sr_next_i)));
endmodule

// File: rtl/sdl_test_mux.sv
module sdl_test_mux
  import sdl_pkg::*;
(
  input  logic [T_W-1:0] tsel_i,
  input  logic           par_mode_i,
  input  logic           s_data_i,
  input  logic           fb_i,
  output logic           test_o
);
  logic sel_val;

  always_comb begin
    unique case (tsel_e'(tsel_i))
      TSEL_DATA: sel_val = s_data_i;
      TSEL_FB:   sel_val = fb_i;
      default:   sel_val = 1'b0;
    endcase
  end

  assign test_o = sel_val && !par_mode_i;
endmodule

// File: rtl/synth_div_loader.sv
module synth_div_loader
  import sdl_pkg::*;
#(
  parameter int M_LOCK_MIN = 250,
  parameter int M_LOCK_MAX = 500
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_load_ni,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           ser_clk_i,
  input  logic           ser_data_i,
  input  logic           ser_load_i,
  input  logic           fb_div_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] tsel_o,
  output logic           test_o,
  output logic           m_range_err_o
);
  localparam int SYNC_W = 5 + M_W + N_W;

  logic [SYNC_W-1:0] pins_raw, pins_s;
  logic              p_load_s, s_clk_s, s_data_s, s_load_s, fb_s;
  logic [M_W-1:0]    par_m_s;
  logic [N_W-1:0]    par_n_s;
  logic              s_clk_d, s_load_d;
  logic              s_clk_rise, s_load_rise, par_mode, shift_en;
  logic [FRAME_W-1:0] sr, sr_next;
  cfg_t              cfg;

  assign pins_raw = {par_load_ni, ser_clk_i, ser_data_i, ser_load_i, fb_div_i,
                     par_m_i, par_n_i};

  sdl_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign {p_load_s, s_clk_s, s_data_s, s_load_s, fb_s, par_m_s, par_n_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_clk_d  <= 1'b0;
      s_load_d <= 1'b0;
    end else begin
      s_clk_d  <= s_clk_s;
      s_load_d <= s_load_s;
    end
  end

  assign s_clk_rise  = s_clk_s && !s_clk_d;
  assign s_load_rise = s_load_s && !s_load_d;
  assign par_mode    = !p_load_s;
  assign shift_en    = !par_mode && s_clk_rise;

  sdl_shift u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .bit_i     (s_data_s),
    .sr_o      (sr),
    .sr_next_o (sr_next)
  );

  sdl_cfg u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .par_mode_i   (par_mode),
    .par_m_i      (par_m_s),
    .par_n_i      (par_n_s),
    .s_load_i     (s_load_s),
    .s_load_rise_i(s_load_rise),
    .s_clk_rise_i (s_clk_rise),
    .sr_i         (sr),
    .sr_next_i    (sr_next),
    .cfg_o        (cfg)
  );

  sdl_test_mux u_tmux (
    .tsel_i    (cfg.tsel),
    .par_mode_i(par_mode),
    .s_data_i  (s_data_s),
    .fb_i      (fb_s),
    .test_o    (test_o)
  );

  assign m_o    = cfg.m;
  assign n_o    = cfg.n;
  assign tsel_o = cfg.tsel;
  assign m_range_err_o = (int'(cfg.m) < M_LOCK_MIN) || (int'(cfg.m) > M_LOCK_MAX);

  assert_test_par_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_mode |-> !test_o);

  assert_rsvd_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsel_o == TSEL_RSVD || tsel_o == TSEL_LOW) |-> !test_o);
endmodule

// File: tb/synth_div_loader_tb.sv
module synth_div_loader_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       par_load_ni = 1'b0;
  logic [8:0] par_m = '0;
  logic [2:0] par_n = '0;
  logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, fb_div = 1'b0;
  logic [8:0] m_o;
  logic [2:0] n_o;
  logic [1:0] tsel_o;
  logic       test_o, m_range_err_o;

  int checks = 0, fails = 0;
  logic [13:0] exp_sr = '0;
  logic [13:0] exp_cfg = '0;  // {tsel, n, m}

  always #2.5 clk = ~clk;

  synth_div_loader u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .par_load_ni(par_load_ni),
    .par_m_i(par_m), .par_n_i(par_n),
    .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_load_i(ser_load),
    .fb_div_i(fb_div),
    .m_o(m_o), .n_o(n_o), .tsel_o(tsel_o), .test_o(test_o),
    .m_range_err_o(m_range_err_o)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req);
    chk(req, {18'd0, tsel_o, n_o, m_o}, {18'd0, exp_cfg});
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    wait_n(4);
    ser_clk = 1'b1;
    wait_n(4);
    exp_sr = {exp_sr[12:0], b};
    if (ser_load) exp_cfg = exp_sr;
    ser_clk = 1'b0;
    wait_n(4);
  endtask

  task automatic shift_frame(input logic [13:0] w);
    for (int i = 13; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    wait_n(5);
    exp_cfg = exp_sr;
    ser_load = 1'b0;
    wait_n(5);
  endtask

  task automatic load_frame(input logic [13:0] w);
    shift_frame(w);
    pulse_load();
  endtask

  initial begin
    wait_n(200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    // R1 reset state
    chk("R1 m", {23'd0, m_o}, 0);
    chk("R1 n/tsel", {27'd0, n_o, tsel_o}, 0);
    chk("R1 test", {31'd0, test_o}, 0);
    rst_ni = 1'b1;
    wait_n(3);
    chk("R1 after release", {18'd0, tsel_o, n_o, m_o}, 0);

    // R2 parallel pass-through sweep
    for (int m = 0; m < 512; m += 13) begin
      par_m = 9'(m);
      par_n = 3'(m % 8);
      fb_div = m[0];
      wait_n(4);
      chk("R2 m", {23'd0, m_o}, m);
      chk("R2 n", {29'd0, n_o}, m % 8);
      chk("R2 tsel/test", {29'd0, tsel_o, test_o}, 0);
    end

    // R9 range flag around both bounds
    for (int m = 0; m < 512; m++) begin
      if (!(m < 6 || (m >= 244 && m <= 256) || (m >= 494 && m <= 506) || m > 505)) continue;
      par_m = 9'(m);
      wait_n(4);
      chk("R9 range", {31'd0, m_range_err_o}, (m < 250 || m > 500) ? 1 : 0);
    end

    // R3 latch on rising strobe
    par_m = 9'd300; par_n = 3'd5;
    wait_n(5);
    par_load_ni = 1'b1;
    wait_n(5);
    par_m = 9'd123; par_n = 3'd2;
    wait_n(6);
    exp_cfg = {2'b00, 3'd5, 9'd300};
    chk_cfg("R3 held");

    // R4/R5/R6 serial frames
    for (int i = 0; i < 8; i++) begin
      logic [13:0] w;
      w = 14'((i * 14'h1357 + 14'h0A5) ^ (i << 11));
      shift_frame(w);
      chk_cfg("R4 no change while shifting");
      pulse_load();
      chk("R5 frame", {18'd0, tsel_o, n_o, m_o}, {18'd0, w});
      send_bit(~w[0]); send_bit(w[3]); send_bit(1'b1);
      chk_cfg("R6 latched after strobe fall");
    end

    // R7 transparent while strobe held high
    ser_load = 1'b1;
    wait_n(5);
    exp_cfg = exp_sr;
    chk_cfg("R7 rise");
    for (int i = 0; i < 10; i++) begin
      send_bit(1'(i % 3 == 0));
      chk_cfg("R7 per clock");
    end
    ser_load = 1'b0;
    wait_n(5);

    // R8 test mux
    load_frame({2'b01, 3'd1, 9'd260});
    for (int k = 0; k < 4; k++) begin
      ser_data = k[0]; fb_div = ~k[0];
      wait_n(4);
      chk("R8 sel 01", {31'd0, test_o}, k[0]);
    end
    load_frame({2'b10, 3'd2, 9'd261});
    for (int k = 0; k < 4; k++) begin
      ser_data = ~k[0]; fb_div = k[0];
      wait_n(4);
      chk("R8 sel 10", {31'd0, test_o}, k[0]);
    end
    load_frame({2'b11, 3'd3, 9'd262});
    for (int k = 0; k < 4; k++) begin
      ser_data = k[0]; fb_div = k[1];
      wait_n(4);
      chk("R8 sel 11", {31'd0, test_o}, 0);
    end
    load_frame({2'b00, 3'd4, 9'd263});
    for (int k = 0; k < 4; k++) begin
      ser_data = k[0]; fb_div = k[1];
      wait_n(4);
      chk("R8 sel 00", {31'd0, test_o}, 0);
    end

    // R2/R8 parallel mode overrides serial select
    load_frame({2'b10, 3'd6, 9'd400});
    fb_div = 1'b1;
    wait_n(4);
    chk("R8 fb before parallel", {31'd0, test_o}, 1);
    par_m = 9'd77; par_n = 3'd7;
    par_load_ni = 1'b0;
    wait_n(5);
    chk("R2 parallel override", {18'd0, tsel_o, n_o, m_o}, {18'd0, 2'b00, 3'd7, 9'd77});
    chk("R8 parallel low", {31'd0, test_o}, 0);
    chk("R9 low m flag", {31'd0, m_range_err_o}, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule